// File: doc/BRIEF.md
# Three-Row Minimum Sketch

This block keeps an approximate running minimum of a small value per network flow, for example the transport header length in bytes. Every update carries a flow key, made of a 32-bit source address, a 32-bit destination address, a 16-bit source port and a 16-bit destination port, together with a 16-bit value. Three independent rows of 32-bit words are each addressed by a different CRC-32 of the key. In each row the addressed word is lowered to the new value if that value is smaller, and the updated word is returned. The estimate for the flow is the smallest of the three returned words.

A hash collision in one row can only pull that row's word below the flow's true minimum. The estimate is wrong only when all three rows collide with flows that carry smaller values. The update path is pipelined and accepts one update per clock. A later update to the same row entry always sees the result of the earlier one, even when the two updates arrive on consecutive cycles. A one-cycle clear input returns every entry to the all-ones word, so that the first update after a clear stores its own value.

The row depth is 2^IDX_W. The default IDX_W of 8 keeps elaboration small; IDX_W of 14 gives 16384 entries per row.

Top module: `min_sketch3`

## Requirements
- R1: After reset, and before any update, `est_valid_o` is low and every row entry reads as 0xFFFFFFFF. The first update of any flow therefore returns its own value.
- R2: The index of row r is the low IDX_W bits of a CRC-32 with polynomial 0x11111111 (r=0), 0x12222222 (r=1) or 0x13333333 (r=2). The CRC is computed over the 12 key bytes in this order: source address, destination address, source port, destination port, each field most significant byte first. Within each byte the bits enter least significant bit first, into a shift register that shifts toward bit 31. The register starts at 0xFFFFFFFF, the result is XORed with 0xFFFFFFFF, and the output is not reflected.
- R3: Each row writes min(stored word, zero-extended value) back to the indexed entry and returns that updated word.
- R4: The estimate is min(min(row0, row1), row2), and `est_o` carries its low VAL_W bits.
- R5: Exactly one `est_valid_o` pulse follows each accepted update (`upd_valid_i` high at a rising edge). It appears after the third rising edge following the accepting edge, in the order the updates were accepted, with one update accepted every cycle.
- R6: Updates that hit the same entry on consecutive cycles behave exactly as if they had been applied one after another with no pipelining.
- R7: `clr_i` high at a rising edge, with no update in flight, sets every entry of every row to 0xFFFFFFFF. Updates accepted after that edge see only cleared entries and their own later writes.
- R8: The estimate is never greater than the value of the update that produced it.
- R9: While `upd_valid_i` is low, the key and value inputs change no stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear all entries to all-ones |
| upd_valid_i | input | 1 | Update is presented this cycle |
| src_addr_i | input | 32 | Flow key: source address |
| dst_addr_i | input | 32 | Flow key: destination address |
| src_port_i | input | 16 | Flow key: source port |
| dst_port_i | input | 16 | Flow key: destination port |
| value_i | input | VAL_W (16) | Value to fold into the flow minimum |
| est_valid_o | output | 1 | Estimate strobe |
| est_o | output | VAL_W (16) | Minimum estimate for the flow |

## Verification
A single flow receives a falling, then rising, sequence of values. This separates the row's minimum update from a plain overwrite, and it shows the first update landing on cleared all-ones entries. The same flow is then sent on consecutive cycles and interleaved with a second flow, which exposes any read of a stale entry that forwarding should have replaced. A long stream of hundreds of flows in a shallow table forces heavy collisions. There the estimate depends on the exact row indices and on taking the minimum across rows, so an error in a polynomial, in the byte or bit order, or in the reduction changes the result. Held-off inputs and a clear followed by larger values tell apart real gating of writes and real entry reset from updates that merely happen to look correct.

// File: rtl/minsk_pkg.sv
package minsk_pkg;
  localparam int unsigned SK_ADDR_W = 32;
  localparam int unsigned SK_PORT_W = 16;
  localparam int unsigned SK_KEY_W  = 2 * SK_ADDR_W + 2 * SK_PORT_W;
  localparam int unsigned SK_KEY_BYTES = SK_KEY_W / 8;
  localparam int unsigned SK_WORD_W = 32;
  localparam int unsigned SK_N_ROWS = 3;
  // Edges from the accepting edge to the edge that raises est_valid_o
  localparam int unsigned SK_EST_LATENCY = 3;

  function automatic logic [31:0] row_poly(input int unsigned r);
    case (r)
      0:       return 32'h1111_1111;
      1:       return 32'h1222_2222;
      default: return 32'h1333_3333;
    endcase
  endfunction

  // Byte-serial CRC, each byte taken LSB first, MSB-first register
  function automatic logic [31:0] key_crc(input logic [31:0] poly,
                                          input logic [SK_KEY_W-1:0] key);
    logic [31:0] c;
    logic [7:0]  byt;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < SK_KEY_BYTES; i++) begin
      byt = key[SK_KEY_W-1-8*i -: 8];
      for (int b = 0; b < 8; b++) begin
        fb = c[31] ^ byt[b];
        c  = {c[30:0], 1'b0} ^ (fb ? poly : 32'h0);
      end
    end
    return c ^ 32'hFFFF_FFFF;
  endfunction

  function automatic logic [SK_WORD_W-1:0] min_word(input logic [SK_WORD_W-1:0] a,
                                                    input logic [SK_WORD_W-1:0] b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/minsk_hash.sv
module minsk_hash import minsk_pkg::*; #(
  parameter int unsigned IDX_W = 8,
  parameter logic [31:0] POLY  = 32'h1111_1111
) (
  input  logic [SK_KEY_W-1:0] key_i,
  output logic [IDX_W-1:0]    idx_o
);
  logic [31:0] crc_w;

  assign crc_w = key_crc(POLY, key_i);
  assign idx_o = IDX_W'(crc_w);
endmodule

// File: rtl/minsk_row.sv
module minsk_row import minsk_pkg::*; #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned VAL_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 rd_valid_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  logic [VAL_W-1:0]     rd_val_i,
  output logic                 res_valid_o,
  output logic [SK_WORD_W-1:0] res_o,
  output logic                 fwd_hit_o,
  output logic                 wr_en_o,
  output logic [SK_WORD_W-1:0] wr_data_o,
  output logic [SK_WORD_W-1:0] wr_ref_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [SK_WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]     live;

  // read stage
  logic                 s2_valid;
  logic [IDX_W-1:0]     s2_idx;
  logic [VAL_W-1:0]     s2_val;
  logic [SK_WORD_W-1:0] s2_rd;

  // most recent write, for same-entry forwarding
  logic                 fw_valid;
  logic [IDX_W-1:0]     fw_idx;
  logic [SK_WORD_W-1:0] fw_data;

  logic [SK_WORD_W-1:0] cur_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_idx   <= '0;
      s2_val   <= '0;
      s2_rd    <= '1;
    end else begin
      s2_valid <= rd_valid_i;
      s2_idx   <= rd_idx_i;
      s2_val   <= rd_val_i;
      s2_rd    <= (clr_i || !live[rd_idx_i]) ? '1 : mem[rd_idx_i];
    end
  end

  assign fwd_hit_o = s2_valid && fw_valid && (fw_idx == s2_idx);
  assign cur_word  = fwd_hit_o ? fw_data : s2_rd;
  assign wr_ref_o  = SK_WORD_W'(s2_val);
  assign wr_data_o = min_word(cur_word, wr_ref_o);
  assign wr_en_o   = s2_valid && !clr_i;

  always_ff @(posedge clk) begin
    if (wr_en_o) mem[s2_idx] <= wr_data_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       live <= '0;
    else if (clr_i)   live <= '0;
    else if (wr_en_o) live[s2_idx] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_valid    <= 1'b0;
      fw_idx      <= '0;
      fw_data     <= '1;
      res_valid_o <= 1'b0;
      res_o       <= '1;
    end else begin
      fw_valid    <= wr_en_o;
      fw_idx      <= s2_idx;
      fw_data     <= wr_data_o;
      res_valid_o <= s2_valid;
      res_o       <= wr_data_o;
    end
  end
endmodule

// File: rtl/minsk_reduce.sv
module minsk_reduce import minsk_pkg::*; #(
  parameter int unsigned VAL_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [SK_N_ROWS-1:0]                 valid_i,
  input  logic [SK_N_ROWS-1:0][SK_WORD_W-1:0]  res_i,
  output logic                                 est_valid_o,
  output logic [VAL_W-1:0]                     est_o
);
  logic [SK_WORD_W-1:0] chain [SK_N_ROWS];

  // row 0 against row 1 first, then each further row in turn
  assign chain[0] = res_i[0];
  for (genvar r = 1; r < SK_N_ROWS; r++) begin : g_chain
    assign chain[r] = min_word(chain[r-1], res_i[r]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_valid_o <= 1'b0;
      est_o       <= '0;
    end else begin
      est_valid_o <= &valid_i;
      est_o       <= VAL_W'(chain[SK_N_ROWS-1]);
    end
  end
endmodule

// File: rtl/min_sketch3.sv
module min_sketch3 import minsk_pkg::*; #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned VAL_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 upd_valid_i,
  input  logic [SK_ADDR_W-1:0] src_addr_i,
  input  logic [SK_ADDR_W-1:0] dst_addr_i,
  input  logic [SK_PORT_W-1:0] src_port_i,
  input  logic [SK_PORT_W-1:0] dst_port_i,
  input  logic [VAL_W-1:0]     value_i,
  output logic                 est_valid_o,
  output logic [VAL_W-1:0]     est_o
);
  logic [SK_KEY_W-1:0] key_w;
  assign key_w = {src_addr_i, dst_addr_i, src_port_i, dst_port_i};

  // hash stage
  logic [SK_N_ROWS-1:0][IDX_W-1:0] hash_idx;
  logic [SK_N_ROWS-1:0][IDX_W-1:0] s1_idx;
  logic                            s1_valid;
  logic [VAL_W-1:0]                s1_val;

  // named row events for the checker
  logic [SK_N_ROWS-1:0]                row_res_valid;
  logic [SK_N_ROWS-1:0][SK_WORD_W-1:0] row_res;
  logic [SK_N_ROWS-1:0]                row_fwd_hit;
  logic [SK_N_ROWS-1:0]                row_wr_en;
  logic [SK_N_ROWS-1:0][SK_WORD_W-1:0] row_wr_data;
  logic [SK_N_ROWS-1:0][SK_WORD_W-1:0] row_wr_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_val   <= '0;
      s1_idx   <= '0;
    end else begin
      s1_valid <= upd_valid_i;
      s1_val   <= value_i;
      s1_idx   <= hash_idx;
    end
  end

  for (genvar r = 0; r < SK_N_ROWS; r++) begin : g_row
    minsk_hash #(
      .IDX_W (IDX_W),
      .POLY  (row_poly(r))
    ) u_hash (
      .key_i (key_w),
      .idx_o (hash_idx[r])
    );

    minsk_row #(
      .IDX_W (IDX_W),
      .VAL_W (VAL_W)
    ) u_row (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (clr_i),
      .rd_valid_i  (s1_valid),
      .rd_idx_i    (s1_idx[r]),
      .rd_val_i    (s1_val),
      .res_valid_o (row_res_valid[r]),
      .res_o       (row_res[r]),
      .fwd_hit_o   (row_fwd_hit[r]),
      .wr_en_o     (row_wr_en[r]),
      .wr_data_o   (row_wr_data[r]),
      .wr_ref_o    (row_wr_ref[r])
    );
  end

  minsk_reduce #(
    .VAL_W (VAL_W)
  ) u_reduce (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (row_res_valid),
    .res_i       (row_res),
    .est_valid_o (est_valid_o),
    .est_o       (est_o)
  );
endmodule

// File: rtl/min_sketch3_chk.sv
module min_sketch3_chk import minsk_pkg::*; #(
  parameter int unsigned VAL_W = 16
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                upd_valid_i,
  input logic [VAL_W-1:0]                    value_i,
  input logic                                est_valid_o,
  input logic [VAL_W-1:0]                    est_o,
  input logic [SK_N_ROWS-1:0]                fwd_hit,
  input logic [SK_N_ROWS-1:0]                wr_en,
  input logic [SK_N_ROWS-1:0][SK_WORD_W-1:0] wr_data,
  input logic [SK_N_ROWS-1:0][SK_WORD_W-1:0] wr_ref
);
  // edges seen since reset, saturating; gates the history-based checks
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= '0;
    else if (since_rst != 3'd7)  since_rst <= since_rst + 3'd1;
  end

  AST_QUIET_START: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < 3'd4) |-> !est_valid_o);  // R1

  // depth 4 = SK_EST_LATENCY + 1 sampling ticks
  AST_EST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4) |-> (est_valid_o == $past(upd_valid_i, 4)));  // R5

  AST_EST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && est_valid_o) |-> (est_o <= $past(value_i, 4)));  // R8

  for (genvar r = 0; r < SK_N_ROWS; r++) begin : g_rowchk
    AST_FWD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 3'd1 && fwd_hit[r]) |-> $past(wr_en[r]));  // R6

    AST_WRITE_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[r] |-> (wr_data[r] <= wr_ref[r]));  // R3
  end
endmodule

bind min_sketch3 min_sketch3_chk #(.VAL_W(VAL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid_i (upd_valid_i),
  .value_i     (value_i),
  .est_valid_o (est_valid_o),
  .est_o       (est_o),
  .fwd_hit     (row_fwd_hit),
  .wr_en       (row_wr_en),
  .wr_data     (row_wr_data),
  .wr_ref      (row_wr_ref)
);

// File: tb/min_sketch3_tb.sv
module min_sketch3_tb;
  localparam int IDX_W = 8;
  localparam int DEPTH = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        upd_valid_i = 1'b0;
  logic [31:0] src_addr_i = '0;
  logic [31:0] dst_addr_i = '0;
  logic [15:0] src_port_i = '0;
  logic [15:0] dst_port_i = '0;
  logic [15:0] value_i = '0;
  logic        est_valid_o;
  logic [15:0] est_o;

  always #2 clk = ~clk;  // 250 MHz

  min_sketch3 #(.IDX_W(IDX_W), .VAL_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .upd_valid_i(upd_valid_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .src_port_i(src_port_i), .dst_port_i(dst_port_i),
    .value_i(value_i), .est_valid_o(est_valid_o), .est_o(est_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic [31:0] mdl [3][DEPTH];
  int          exp_val [$];
  int          exp_in  [$];
  int          exp_cyc [$];
  string       exp_tag [$];

  function automatic logic [31:0] poly_of(int r);
    return (r == 0) ? 32'h11111111 : (r == 1) ? 32'h12222222 : 32'h13333333;
  endfunction

  // byte-at-a-time form: reverse the byte, XOR into the top, shift 8 times
  function automatic logic [31:0] ref_crc(logic [31:0] poly, logic [95:0] k);
    logic [31:0] c;
    logic [7:0]  b;
    logic [7:0]  rb;
    c = 32'hFFFFFFFF;
    for (int n = 0; n < 12; n++) begin
      b = k[95-8*n -: 8];
      for (int j = 0; j < 8; j++) rb[j] = b[7-j];
      c = c ^ {rb, 24'h0};
      for (int j = 0; j < 8; j++) c = c[31] ? ((c << 1) ^ poly) : (c << 1);
    end
    return ~c;
  endfunction

  task automatic note(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < DEPTH; i++) mdl[r][i] = 32'hFFFFFFFF;
  endtask

  task automatic push(logic [31:0] s, logic [31:0] d, logic [15:0] sp,
                      logic [15:0] dp, logic [15:0] v, string tag);
    logic [31:0] best;
    logic [31:0] m;
    int          ix;
    @(negedge clk);
    src_addr_i = s; dst_addr_i = d; src_port_i = sp; dst_port_i = dp;
    value_i = v; upd_valid_i = 1'b1;
    best = 32'hFFFFFFFF;
    for (int r = 0; r < 3; r++) begin
      ix = int'(ref_crc(poly_of(r), {s, d, sp, dp}) & (DEPTH - 1));
      m  = mdl[r][ix];
      if ({16'h0, v} < m) m = {16'h0, v};
      mdl[r][ix] = m;
      if (m < best) best = m;
    end
    exp_val.push_back(int'(best[15:0]));
    exp_in.push_back(int'(v));
    exp_cyc.push_back(cyc + 4);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    upd_valid_i = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // result monitor, sampled 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n && est_valid_o) begin
      if (exp_val.size() == 0) begin
        note(0, "R5 unexpected strobe", 1, 0);
      end else begin
        int ev, ei, ec;
        string tg;
        ev = exp_val.pop_front(); ei = exp_in.pop_front();
        ec = exp_cyc.pop_front(); tg = exp_tag.pop_front();
        note(int'(est_o) == ev, tg, int'(est_o), ev);
        note(cyc == ec, "R5 latency", cyc, ec);
        note(int'(est_o) <= ei, "R8 bound", int'(est_o), ei);
      end
    end
  end

  task automatic t_reset();
    model_clear();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    note(est_valid_o == 1'b0, "R1 strobe in reset", int'(est_valid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    note(est_valid_o == 1'b0, "R1 strobe after reset", int'(est_valid_o), 0);
  endtask

  task automatic t_first_and_min();
    push(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, 16'd40, "R1 first value");
    idle(6);
    push(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, 16'd60, "R3 larger kept");
    idle(6);
    push(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, 16'd20, "R3 smaller taken");
    idle(6);
    push(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, 16'd32, "R3 min held");
    idle(6);
  endtask

  task automatic t_back_to_back();
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd40, "R6 b2b");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd30, "R6 b2b");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd35, "R6 b2b");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd12, "R6 b2b");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd60, "R6 b2b");
    push(32'hC0A80303, 32'hC0A80404, 16'd6000, 16'd53,  16'd44, "R6 interleave");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd50, "R6 interleave");
    push(32'hC0A80303, 32'hC0A80404, 16'd6000, 16'd53,  16'd24, "R6 interleave");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd8,  "R6 interleave");
    push(32'hC0A80303, 32'hC0A80404, 16'd6000, 16'd53,  16'd28, "R6 interleave");
    idle(6);
  endtask

  task automatic t_ignored();
    // flow from t_first_and_min holds 20; offer 1 with valid low
    @(negedge clk);
    upd_valid_i = 1'b0;
    src_addr_i = 32'h0A000001; dst_addr_i = 32'h0A000002;
    src_port_i = 16'd1234; dst_port_i = 16'd80; value_i = 16'd1;
    repeat (5) @(negedge clk);
    push(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, 16'd55, "R9 held-off input");
    idle(6);
  endtask

  task automatic t_clear();
    @(negedge clk);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
    model_clear();
    push(32'h0A000001, 32'h0A000002, 16'd1234, 16'd80, 16'd50, "R7 after clear");
    push(32'hC0A80101, 32'hC0A80202, 16'd5000, 16'd443, 16'd60, "R7 after clear");
    idle(6);
  endtask

  task automatic t_stream();
    logic [31:0] st;
    int f;
    st = 32'h1234_5678;
    for (int n = 0; n < 700; n++) begin
      st = st * 32'd1103515245 + 32'd12345;
      f  = int'(st[23:8]) % 300;
      push(32'h0A000000 + f, 32'hC0A80001 ^ (f << 8), 16'(1000 + f), 16'd80,
           16'(20 + (int'(st[30:16]) % 41)), "R2 R4 stream");
    end
    idle(8);
  endtask

  initial begin
    t_reset();
    t_first_and_min();
    t_back_to_back();
    t_ignored();
    t_clear();
    t_stream();
    idle(4);
    note(exp_val.size() == 0, "R5 missing strobes", exp_val.size(), 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule